// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block gives a host a window onto sixteen byte-wide configuration registers through just two I/O addresses. A write to the lower address selects a register, and the upper address then reads or writes the selected register. The registers occupy indices 0x60 to 0x6F. Index 0x63 is not implemented. Any index outside that range has no storage behind it.

Each register carries its own constant mask of writable bits, so the bits outside a register's mask keep their value. Two identification fields always hold the revision code 2. At reset every register is loaded with its default value, filtered through the same mask and forcing that a write uses. A few stored bits leave the block as control signals:
- a one-cycle CPU reset request;
- the A20 gate enable;
- the expanded-memory enable;
- the upper-memory relocation enable.

The highest register reads back the live A20 state on one of its bits.

Top module: `cfg_index_port`

## Requirements
- R1: A write to the index port (PORT_BASE, default 0x0022) stores the byte as the current index. A read of the index port returns that index. The index resets to 0x00.
- R2: After reset, the data port reads these values at indices 0x60..0x6F: 80 45 3C 00 40 FE 00 00 00 00 A0 63 10 00 00 0x (hex). At 0x6F, bit 1 shows the A20 sense input and the other bits are 0.
- R3: A data-port write changes only the writable bits of the selected register. The writable masks are:
  - 0x34 at index 0x60;
  - 0x3F at index 0x62;
  - 0x60 at index 0x64;
  - 0x80 at index 0x66;
  - 0xE0 at index 0x6A;
  - 0xF0 at index 0x6C;
  - 0xE6 at index 0x6F;
  - 0xFF at every other implemented index.
- R4: Bits 7:6 of index 0x60 and bits 6:5 of index 0x64 always read 2'b10, whatever was written.
- R5: A data-port read at index 0x6F returns the stored byte with bit 1 replaced by the a20_sense input.
- R6: A data-port read at any index outside 0x60..0x6F returns 0xFF. A data-port write at such an index has no effect. Index 0x63 ignores writes and reads 0x00.
- R7: cpu_reset_req is high for exactly one cycle, in the cycle after the clock edge at which bit 5 of index 0x60 goes from 0 to 1. Writing that bit when it is already 1, or writing it to 0, gives no pulse.
- R8: a20_gate_en equals the inverse of bit 1 of index 0x6F.
- R9: ems_enable equals bit 4 of index 0x6B, and relocate_enable equals bit 6 of index 0x6B.
- R10: Accesses to any address other than the two ports change no state, and such reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0xFF when nothing is decoded |
| a20_sense | input | 1 | Live A20 state, shown on bit 1 of index 0x6F |
| cpu_reset_req | output | 1 | One-cycle CPU reset request |
| a20_gate_en | output | 1 | A20 gate enable |
| ems_enable | output | 1 | Expanded-memory enable |
| relocate_enable | output | 1 | Upper-memory relocation enable |

## Verification
The bench writes all-ones and then all-zeros to every index, which exposes any wrong mask, and any revision field that is ORed rather than overridden; an ORed field would read 2'b11 at index 0x64 after the all-ones pass. It writes bit 5 of index 0x60 twice in a row, so a design that compares data instead of detecting a stored edge, or that holds a level, would pulse again or stay high. It reads index 0x6F with both values of the A20 sense input, which catches a design that returns the stored bit. It writes to index 0x63, to an out-of-range index and to a foreign address, which catches decoders that alias onto a neighbouring register.

// File: rtl/cfgport_pkg.sv
// Package: constants and per-slot tables for the indexed configuration port.
// Assumes slots are numbered 0..NUM_REGS-1 from the first register index.
package cfgport_pkg;

    localparam int          DATA_W       = 8;
    localparam int          NUM_REGS     = 16;
    localparam logic [7:0]  REG_BASE_IDX = 8'h60;
    localparam int          SLOT_CPU     = 0;   // holds the alternate-reset bit
    localparam int          SLOT_MEMCFG  = 11;  // holds the memory enables
    localparam int          SLOT_MISC    = 15;  // holds the A20 control bit
    localparam int          RST_BIT      = 5;
    localparam int          EMS_BIT      = 4;
    localparam int          RELOC_BIT    = 6;
    localparam int          A20_BIT      = 1;

    // Decoded bus cycle.
    typedef struct packed {
        logic idx_we;
        logic data_we;
        logic idx_rd;
        logic data_rd;
    } bus_dec_t;

    // Writable-bit mask of a slot.
    function automatic logic [7:0] slot_wmask(input int s);
        case (s)
            0:       return 8'h34;
            2:       return 8'h3F;
            3:       return 8'h00;
            4:       return 8'h60;
            6:       return 8'h80;
            10:      return 8'hE0;
            12:      return 8'hF0;
            15:      return 8'hE6;
            default: return 8'hFF;
        endcase
    endfunction

    // Unfiltered reset value of a slot.
    function automatic logic [7:0] slot_default(input int s);
        case (s)
            0:       return 8'h0A;
            1:       return 8'h45;
            2:       return 8'hFC;
            5:       return 8'hFE;
            10:      return 8'hA0;
            11:      return 8'h63;
            12:      return 8'h10;
            15:      return 8'h12;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of a slot that are forced on every update.
    function automatic logic [7:0] slot_fmask(input int s);
        case (s)
            0:       return 8'hC0;
            4:       return 8'h60;
            default: return 8'h00;
        endcase
    endfunction

    // Value driven into the forced bits (revision code 2).
    function automatic logic [7:0] slot_fval(input int s);
        case (s)
            0:       return 8'h80;
            4:       return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
// Module: cfgport_decode
// Turns the address and strobes into index-port and data-port cycles.
// Assumes the data port sits at PORT_BASE + 1.
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'h0022
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bus_dec_t          dec
);

    localparam logic [ADDR_W-1:0] DATA_PORT = PORT_BASE + 1'b1;

    logic hit_idx;
    logic hit_data;

    // Compare the address against both ports and qualify it with the strobes.
    always_comb begin
        hit_idx     = (addr == PORT_BASE);
        hit_data    = (addr == DATA_PORT);
        dec.idx_we  = wr && hit_idx;
        dec.data_we = wr && hit_data;
        dec.idx_rd  = rd && hit_idx;
        dec.data_rd = rd && hit_data;
    end

endmodule

// File: rtl/cfgport_regfile.sv
// Module: cfgport_regfile
// One byte per slot: masked writes, forced revision fields, masked defaults.
// Assumes the write is accepted on the edge at which data_we is high.
module cfgport_regfile
    import cfgport_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   data_we,
    input  logic [7:0]             index,
    input  logic [DATA_W-1:0]      wdata,
    output logic [N-1:0][DATA_W-1:0] regs_q
);

    for (genvar s = 0; s < N; s++) begin : g_slot
        localparam logic [7:0] SLOT_IDX = REG_BASE_IDX + 8'(s);
        localparam logic [7:0] WMASK    = slot_wmask(s);
        localparam logic [7:0] FMASK    = slot_fmask(s);
        localparam logic [7:0] FVAL     = slot_fval(s);
        localparam logic [7:0] RST_VAL  = ((slot_default(s) & WMASK) & ~FMASK) | FVAL;

        logic       hit;
        logic [7:0] merged;

        // Select the slot and merge the writable bits with the held bits.
        always_comb begin
            hit    = data_we && (index == SLOT_IDX);
            merged = (((regs_q[s] & ~WMASK) | (wdata & WMASK)) & ~FMASK) | FVAL;
        end

        // Hold the slot: load the default at reset, take the merged byte on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[s] <= RST_VAL;
            else if (hit)
                regs_q[s] <= merged;
        end
    end

endmodule

// File: rtl/cfgport_ctrl.sv
// Module: cfgport_ctrl
// Derives the control outputs from stored register bits.
// Assumes the reset-request bit resets to 0.
module cfgport_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_bit,
    input  logic a20_bit,
    input  logic ems_bit,
    input  logic reloc_bit,
    output logic cpu_reset_req,
    output logic a20_gate_en,
    output logic ems_enable,
    output logic relocate_enable
);

    logic rst_bit_d;

    // Delay the reset-request bit by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_bit_d <= 1'b0;
        else
            rst_bit_d <= rst_bit;
    end

    // Form the one-cycle pulse and the level outputs.
    always_comb begin
        cpu_reset_req   = rst_bit && !rst_bit_d;
        a20_gate_en     = !a20_bit;
        ems_enable      = ems_bit;
        relocate_enable = reloc_bit;
    end

endmodule

// File: rtl/cfgport_rdmux.sv
// Module: cfgport_rdmux
// Builds the read data for the index and data ports.
// Assumes undecoded or out-of-range reads float high (0xFF).
module cfgport_rdmux
    import cfgport_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  bus_dec_t                 dec,
    input  logic [7:0]               index,
    input  logic [N-1:0][DATA_W-1:0] regs_q,
    input  logic                     a20_sense,
    output logic [DATA_W-1:0]        rdata
);

    logic [DATA_W-1:0] sel;

    // Pick the slot addressed by the index; patch live A20 into the last slot.
    always_comb begin
        sel = 8'hFF;
        for (int s = 0; s < N; s++) begin
            if (index == REG_BASE_IDX + 8'(s)) begin
                sel = regs_q[s];
                if (s == SLOT_MISC)
                    sel[A20_BIT] = a20_sense;
            end
        end
    end

    // Route the port that is being read.
    always_comb begin
        if (dec.idx_rd)
            rdata = index;
        else if (dec.data_rd)
            rdata = sel;
        else
            rdata = 8'hFF;
    end

endmodule

// File: rtl/cfg_index_port.sv
// Module: cfg_index_port (top)
// Index/data access to sixteen configuration registers, with control outputs.
// Assumes single-cycle strobes, and a20_sense synchronous to clk.
module cfg_index_port
    import cfgport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'h0022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              a20_sense,
    output logic              cpu_reset_req,
    output logic              a20_gate_en,
    output logic              ems_enable,
    output logic              relocate_enable
);

    bus_dec_t                          dec;
    logic [7:0]                        index_q;
    logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q;

    cfgport_decode #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .dec  (dec)
    );

    // Latch the index on an index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= 8'h00;
        else if (dec.idx_we)
            index_q <= bus_wdata;
    end

    cfgport_regfile #(.N(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (dec.data_we),
        .index   (index_q),
        .wdata   (bus_wdata),
        .regs_q  (regs_q)
    );

    cfgport_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .rst_bit         (regs_q[SLOT_CPU][RST_BIT]),
        .a20_bit         (regs_q[SLOT_MISC][A20_BIT]),
        .ems_bit         (regs_q[SLOT_MEMCFG][EMS_BIT]),
        .reloc_bit       (regs_q[SLOT_MEMCFG][RELOC_BIT]),
        .cpu_reset_req   (cpu_reset_req),
        .a20_gate_en     (a20_gate_en),
        .ems_enable      (ems_enable),
        .relocate_enable (relocate_enable)
    );

    cfgport_rdmux #(.N(NUM_REGS)) u_rdmux (
        .dec       (dec),
        .index     (index_q),
        .regs_q    (regs_q),
        .a20_sense (a20_sense),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/cfg_index_port_sva.sv
// Module: cfg_index_port_sva
// Protocol checks on the configuration port, bound into the top module.
module cfg_index_port_sva #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'h0022
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        index_q,
    input logic              cpu_reset_req,
    input logic              a20_gate_en,
    input logic              ems_enable
);

    localparam logic [ADDR_W-1:0] DATA_PORT = PORT_BASE + 1'b1;

    // R1: an index write is held as the new index.
    assert_index_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_BASE) |=> (index_q == $past(bus_wdata)));

    // R4: the revision field of index 0x60 reads 2.
    assert_rev_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_PORT && index_q == 8'h60) |-> (bus_rdata[7:6] == 2'b10));

    // R7: the reset request never lasts two cycles.
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_req |=> !cpu_reset_req);

    // R7: a pulse follows a write of bit 5 at index 0x60.
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_req |-> $past(bus_wr && bus_addr == DATA_PORT && index_q == 8'h60 && bus_wdata[5]));

    // R8: a write at index 0x6F sets the gate to the inverse of bit 1.
    assert_a20_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_PORT && index_q == 8'h6F) |=> (a20_gate_en == !$past(bus_wdata[1])));

    // R9: the expanded-memory enable moves only on a write at index 0x6B.
    assert_ems_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DATA_PORT && index_q == 8'h6B) |=> $stable(ems_enable));

    // R10: reads of foreign addresses float high.
    assert_foreign_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != PORT_BASE && bus_addr != DATA_PORT) |-> (bus_rdata == 8'hFF));

endmodule

bind cfg_index_port cfg_index_port_sva #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .index_q       (index_q),
    .cpu_reset_req (cpu_reset_req),
    .a20_gate_en   (a20_gate_en),
    .ems_enable    (ems_enable)
);

// File: tb/cfg_index_port_tb.sv
// Scoreboard bench: drivers queue expected read bytes, a monitor compares them.
module cfg_index_port_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] IDX_PORT   = 16'h0022;
    localparam logic [15:0] DAT_PORT   = 16'h0023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        a20_sense = 1'b0;
    logic        cpu_reset_req, a20_gate_en, ems_enable, relocate_enable;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // Bench model, written from the requirements.
    logic [7:0] m_idx;
    logic [7:0] m_reg [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .a20_sense(a20_sense),
        .cpu_reset_req(cpu_reset_req), .a20_gate_en(a20_gate_en),
        .ems_enable(ems_enable), .relocate_enable(relocate_enable)
    );

    function automatic logic [7:0] wm(input int s);
        case (s)
            0: return 8'h34;  2: return 8'h3F;  3: return 8'h00;  4: return 8'h60;
            6: return 8'h80; 10: return 8'hE0; 12: return 8'hF0; 15: return 8'hE6;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_data();
        logic [7:0] v;
        if (m_idx >= 8'h60 && m_idx <= 8'h6E) return m_reg[m_idx - 8'h60];
        if (m_idx == 8'h6F) begin
            v = m_reg[15];
            v[1] = a20_sense;
            return v;
        end
        return 8'hFF;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        int s;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a == IDX_PORT) m_idx = d;
        else if (a == DAT_PORT && m_idx >= 8'h60 && m_idx <= 8'h6F) begin
            s = int'(m_idx - 8'h60);
            m_reg[s] = (m_reg[s] & ~wm(s)) | (d & wm(s));
            if (s == 0) m_reg[0][7:6] = 2'b10;
            if (s == 4) m_reg[4][6:5] = 2'b10;
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] idx, input string tag);
        wr(IDX_PORT, idx);
        rd(DAT_PORT, exp_data(), tag);
    endtask

    task automatic check_outs(input string tag);
        #1;
        check({tag, " R8 a20_gate_en"}, {7'd0, a20_gate_en}, {7'd0, ~m_reg[15][1]});
        check({tag, " R9 ems_enable"}, {7'd0, ems_enable}, {7'd0, m_reg[11][4]});
        check({tag, " R9 relocate_enable"}, {7'd0, relocate_enable}, {7'd0, m_reg[11][6]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Monitor: compare each read against the head of the scoreboard.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: actual %02h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        m_idx = 8'h00;
        m_reg = '{8'h80, 8'h45, 8'h3C, 8'h00, 8'h40, 8'hFE, 8'h00, 8'h00,
                  8'h00, 8'h00, 8'hA0, 8'h63, 8'h10, 8'h00, 8'h00, 8'h02};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: index reset value; R6: data read at index 0x00.
        rd(IDX_PORT, 8'h00, "R1 index reset");
        rd(DAT_PORT, 8'hFF, "R6 data read at index 00");
        check("R7 no pulse after reset", {7'd0, cpu_reset_req}, 8'h00);
        check_outs("reset");

        // R2: all defaults, A20 sense low.
        for (int i = 0; i < 16; i++) rd_reg(8'h60 + 8'(i), $sformatf("R2 default idx %02h", 8'h60 + i));
        // R5: live A20 on bit 1.
        a20_sense = 1'b1;
        rd_reg(8'h6F, "R5 a20 sense high");
        a20_sense = 1'b0;
        rd_reg(8'h6F, "R5 a20 sense low");

        // R3/R4: all ones, then all zeros.
        for (int i = 0; i < 16; i++) begin
            wr(IDX_PORT, 8'h60 + 8'(i));
            wr(DAT_PORT, 8'hFF);
        end
        for (int i = 0; i < 16; i++) rd_reg(8'h60 + 8'(i), $sformatf("R3 R4 ones idx %02h", 8'h60 + i));
        check_outs("ones");
        for (int i = 0; i < 16; i++) begin
            wr(IDX_PORT, 8'h60 + 8'(i));
            wr(DAT_PORT, 8'h00);
        end
        for (int i = 0; i < 16; i++) rd_reg(8'h60 + 8'(i), $sformatf("R3 R4 zeros idx %02h", 8'h60 + i));
        check_outs("zeros");

        // R7: pulse on 0->1, none on repeat, again after clearing.
        wr(IDX_PORT, 8'h60);
        wr(DAT_PORT, 8'h20);
        #1 check("R7 pulse high", {7'd0, cpu_reset_req}, 8'h01);
        @(negedge clk); #1 check("R7 pulse low next", {7'd0, cpu_reset_req}, 8'h00);
        wr(DAT_PORT, 8'h24);
        #1 check("R7 no pulse bit held", {7'd0, cpu_reset_req}, 8'h00);
        wr(DAT_PORT, 8'h00);
        #1 check("R7 no pulse on clear", {7'd0, cpu_reset_req}, 8'h00);
        wr(DAT_PORT, 8'h20);
        #1 check("R7 pulse again", {7'd0, cpu_reset_req}, 8'h01);
        rd(DAT_PORT, exp_data(), "R4 rev after pulse writes");

        // R8: A20 gate.
        wr(IDX_PORT, 8'h6F);
        wr(DAT_PORT, 8'h00);
        check_outs("a20 on");
        wr(DAT_PORT, 8'h02);
        check_outs("a20 off");

        // R9: memory enables.
        wr(IDX_PORT, 8'h6B);
        wr(DAT_PORT, 8'h10);
        check_outs("ems only");
        wr(DAT_PORT, 8'h40);
        check_outs("reloc only");

        // R1: arbitrary index readback.
        wr(IDX_PORT, 8'hA5);
        rd(IDX_PORT, 8'hA5, "R1 index A5");
        // R6: out-of-range write and read.
        wr(DAT_PORT, 8'h00);
        rd(DAT_PORT, 8'hFF, "R6 out of range A5");
        wr(IDX_PORT, 8'h70);
        wr(DAT_PORT, 8'h00);
        rd(DAT_PORT, 8'hFF, "R6 out of range 70");
        check_outs("R6 after 70");
        rd_reg(8'h6F, "R6 6F untouched");
        rd_reg(8'h6B, "R6 6B untouched");
        wr(IDX_PORT, 8'h63);
        wr(DAT_PORT, 8'hFF);
        rd(DAT_PORT, 8'h00, "R6 idx 63 ignores write");

        // R10: foreign addresses.
        wr(IDX_PORT, 8'h6F);
        wr(16'h0024, 8'h00);
        wr(16'h0122, 8'h61);
        check_outs("R10 foreign write");
        rd(16'h0024, 8'hFF, "R10 foreign read");
        rd(IDX_PORT, 8'h6F, "R10 index unchanged");
        rd(DAT_PORT, exp_data(), "R10 6F unchanged");

        repeat (2) @(negedge clk);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end

endmodule